// File: doc/BRIEF.md
# CPU Status Latch and Bus Cycle Decoder

This block sits next to an 8-bit processor that places a status word on its shared data bus during the first part of every machine cycle. It captures the word when the processor's `sync` pulse is high and holds it until the next pulse. From the held word it derives a machine-cycle class and a set of per-cycle flags. It also produces the control strobes for memory read, memory write, port read, port write and interrupt acknowledge. The data bus can carry status and then data in the same cycle, so each strobe is formed from held status bits gated by the live `dbin` (read enable, active high) or `wr_n` (write enable, active low) input.

An instruction takes between one and five machine cycles, and each cycle carries its own status word. A `sync` pulse per cycle therefore reloads the held word. Out of reset no strobe can fire until the first status word has been captured. The interrupt-acknowledge strobe tells the surrounding logic to place a restart opcode on the bus in place of memory data.

Top module: `cpu_status_decoder`

## Requirements
- R1: On a rising clock edge with `sync` high the held word takes the value of `data_in`. On edges with `sync` low it keeps its value. The held word is visible on `status_word`.
- R2: While reset is applied and until the first `sync` capture after reset, `status_word` is 0, `cyc_valid` is 0, `cyc_type` is 0 (idle), `cyc_illegal` is 0 and all five strobes are 0, even with `dbin` high and `wr_n` low.
- R3: The held word is classified on `cyc_type` as follows: 8'hA2 fetch=1, 8'h82 memory read=2, 8'h00 memory write=3, 8'h86 stack read=4, 8'h04 stack write=5, 8'h42 port input=6, 8'h10 port output=7, 8'h23 interrupt acknowledge=8, 8'h8A halt acknowledge=9, 8'h2B interrupt acknowledge while halted=10.
- R4: After a capture, any held word outside the ten patterns of R3 gives `cyc_type` 15 and `cyc_illegal` 1. The ten listed patterns give `cyc_illegal` 0.
- R5: `mem_rd` is high exactly when a word has been captured, bit 7 (memory-read marker) of the held word is 1 and `dbin` is high.
- R6: `io_rd` is high exactly when a word has been captured, bit 6 (input marker) is 1 and `dbin` is high.
- R7: `mem_wr` is high exactly when a word has been captured, bit 4 (output marker) is 0, bit 1 (active-low write marker) is 0 and `wr_n` is low.
- R8: `io_wr` is high exactly when a word has been captured, bit 4 is 1 and `wr_n` is low.
- R9: `int_ack` is high exactly when a word has been captured, bit 0 (interrupt-acknowledge marker) is 1 and `dbin` is high.
- R10: `fetch_flag`, `stack_flag` and `halt_flag` follow bits 5, 2 and 3 of the held word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| data_in | input | 8 | Processor data bus as seen by the block |
| sync | input | 1 | High while the bus carries the status word |
| dbin | input | 1 | Processor read enable, active high |
| wr_n | input | 1 | Processor write enable, active low |
| status_word | output | 8 | Held status word |
| cyc_valid | output | 1 | A status word has been captured since reset |
| cyc_type | output | 4 | Machine-cycle class code |
| cyc_illegal | output | 1 | Held word matches no known cycle |
| fetch_flag | output | 1 | Cycle fetches the first opcode byte |
| stack_flag | output | 1 | Address is a stack address |
| halt_flag | output | 1 | Halt acknowledge cycle |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Port read strobe |
| io_wr | output | 1 | Port write strobe |
| int_ack | output | 1 | Interrupt acknowledge strobe |

## Verification
The interrupt acknowledge taken while halted is the cycle in which two functions meet: the interrupt-acknowledge strobe must fire under `dbin` while the halt flag stays raised, and the memory-read strobe must stay low because the same word carries no memory-read marker. The bench captures 8'h2B, raises `dbin` and checks the cycle class, the halt flag and all five strobes together. In a second case, 8'hFF deliberately sets every marker. With `dbin` high, three read-side strobes must then rise at once. With `wr_n` low, the port write must win over the memory write.

// File: rtl/stsdec_pkg.sv
package stsdec_pkg;

  localparam int unsigned SW_W = 8;

  // bit positions inside the status word
  localparam int unsigned B_INTA  = 0;
  localparam int unsigned B_WO_N  = 1;
  localparam int unsigned B_STACK = 2;
  localparam int unsigned B_HALT  = 3;
  localparam int unsigned B_OUT   = 4;
  localparam int unsigned B_M1    = 5;
  localparam int unsigned B_INP   = 6;
  localparam int unsigned B_MEMR  = 7;

  // recognised status patterns
  localparam logic [SW_W-1:0] PAT_FETCH  = 8'hA2;
  localparam logic [SW_W-1:0] PAT_MRD    = 8'h82;
  localparam logic [SW_W-1:0] PAT_MWR    = 8'h00;
  localparam logic [SW_W-1:0] PAT_SRD    = 8'h86;
  localparam logic [SW_W-1:0] PAT_SWR    = 8'h04;
  localparam logic [SW_W-1:0] PAT_IN     = 8'h42;
  localparam logic [SW_W-1:0] PAT_OUT    = 8'h10;
  localparam logic [SW_W-1:0] PAT_IACK   = 8'h23;
  localparam logic [SW_W-1:0] PAT_HACK   = 8'h8A;
  localparam logic [SW_W-1:0] PAT_IHACK  = 8'h2B;

  typedef enum logic [3:0] {
    CT_IDLE     = 4'd0,
    CT_FETCH    = 4'd1,
    CT_MEM_RD   = 4'd2,
    CT_MEM_WR   = 4'd3,
    CT_STK_RD   = 4'd4,
    CT_STK_WR   = 4'd5,
    CT_PORT_IN  = 4'd6,
    CT_PORT_OUT = 4'd7,
    CT_INT_ACK  = 4'd8,
    CT_HALT_ACK = 4'd9,
    CT_INT_HALT = 4'd10,
    CT_ILLEGAL  = 4'd15
  } cyc_type_e;

endpackage

// File: rtl/stsdec_rst_sync.sv
module stsdec_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/stsdec_capture.sv
module stsdec_capture
  import stsdec_pkg::*;
#(
  parameter int unsigned W = SW_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sync,
  input  logic [W-1:0] data_in,
  output logic [W-1:0] word_q,
  output logic         valid_q
);

  logic [W-1:0] word_d;
  logic         valid_d;
  logic         load_en;

  always_comb begin
    load_en = sync;
    word_d  = load_en ? data_in : word_q;
    valid_d = valid_q | load_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      word_q  <= word_d;
      valid_q <= valid_d;
    end
  end

  assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (word_q == $past(data_in)));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sync |=> $stable(word_q));

  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_q && !sync) |=> !valid_q);

endmodule

// File: rtl/stsdec_classify.sv
module stsdec_classify
  import stsdec_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid,
  input  logic [SW_W-1:0] word,
  output cyc_type_e       ctype,
  output logic            illegal
);

  cyc_type_e decoded;

  always_comb begin
    unique case (word)
      PAT_FETCH: decoded = CT_FETCH;
      PAT_MRD:   decoded = CT_MEM_RD;
      PAT_MWR:   decoded = CT_MEM_WR;
      PAT_SRD:   decoded = CT_STK_RD;
      PAT_SWR:   decoded = CT_STK_WR;
      PAT_IN:    decoded = CT_PORT_IN;
      PAT_OUT:   decoded = CT_PORT_OUT;
      PAT_IACK:  decoded = CT_INT_ACK;
      PAT_HACK:  decoded = CT_HALT_ACK;
      PAT_IHACK: decoded = CT_INT_HALT;
      default:   decoded = CT_ILLEGAL;
    endcase
  end

  always_comb begin
    ctype   = valid ? decoded : CT_IDLE;
    illegal = valid && (decoded == CT_ILLEGAL);
  end

  assert_fetch_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctype == CT_FETCH) |-> (word[B_M1] && word[B_MEMR] && !word[B_INTA]));

  assert_stack_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctype == CT_STK_RD) || (ctype == CT_STK_WR)) |-> word[B_STACK]);

  assert_illegal_only_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> valid);

endmodule

// File: rtl/stsdec_strobes.sv
module stsdec_strobes (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic b_inta,
  input  logic b_wo_n,
  input  logic b_out,
  input  logic b_inp,
  input  logic b_memr,
  input  logic dbin,
  input  logic wr_n,
  output logic mem_rd,
  output logic mem_wr,
  output logic io_rd,
  output logic io_wr,
  output logic int_ack
);

  logic rd_win;
  logic wr_win;

  always_comb begin
    rd_win  = valid && dbin;
    wr_win  = valid && !wr_n;
    mem_rd  = rd_win && b_memr;
    io_rd   = rd_win && b_inp;
    int_ack = rd_win && b_inta;
    mem_wr  = wr_win && !b_out && !b_wo_n;
    io_wr   = wr_win && b_out;
  end

  assert_memrd_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> dbin);

  assert_iord_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd |-> dbin);

  assert_memwr_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (!wr_n && !io_wr));

  assert_iowr_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr |-> !wr_n);

  assert_intack_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |-> dbin);

  assert_quiet_invalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> !(mem_rd || mem_wr || io_rd || io_wr || int_ack));

endmodule

// File: rtl/cpu_status_decoder.sv
module cpu_status_decoder
  import stsdec_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] data_in,
  input  logic       sync,
  input  logic       dbin,
  input  logic       wr_n,
  output logic [7:0] status_word,
  output logic       cyc_valid,
  output logic [3:0] cyc_type,
  output logic       cyc_illegal,
  output logic       fetch_flag,
  output logic       stack_flag,
  output logic       halt_flag,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       io_rd,
  output logic       io_wr,
  output logic       int_ack
);

  logic            rst_n_int;
  logic [SW_W-1:0] word;
  logic            valid;
  cyc_type_e       ctype;

  stsdec_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  stsdec_capture #(.W(SW_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .sync    (sync),
    .data_in (data_in),
    .word_q  (word),
    .valid_q (valid)
  );

  stsdec_classify u_cls (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .valid   (valid),
    .word    (word),
    .ctype   (ctype),
    .illegal (cyc_illegal)
  );

  stsdec_strobes u_stb (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .valid   (valid),
    .b_inta  (word[B_INTA]),
    .b_wo_n  (word[B_WO_N]),
    .b_out   (word[B_OUT]),
    .b_inp   (word[B_INP]),
    .b_memr  (word[B_MEMR]),
    .dbin    (dbin),
    .wr_n    (wr_n),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr),
    .io_rd   (io_rd),
    .io_wr   (io_wr),
    .int_ack (int_ack)
  );

  always_comb begin
    status_word = word;
    cyc_valid   = valid;
    cyc_type    = ctype;
    fetch_flag  = word[B_M1];
    stack_flag  = word[B_STACK];
    halt_flag   = word[B_HALT];
  end

endmodule

// File: tb/sim_cpu_status_decoder.sv
`timescale 1ns/1ps
module sim_cpu_status_decoder;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] data_in;
  logic       sync, dbin, wr_n;
  logic [7:0] status_word;
  logic       cyc_valid, cyc_illegal, fetch_flag, stack_flag, halt_flag;
  logic [3:0] cyc_type;
  logic       mem_rd, mem_wr, io_rd, io_wr, int_ack;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  cpu_status_decoder u0 (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .sync(sync), .dbin(dbin),
    .wr_n(wr_n), .status_word(status_word), .cyc_valid(cyc_valid),
    .cyc_type(cyc_type), .cyc_illegal(cyc_illegal), .fetch_flag(fetch_flag),
    .stack_flag(stack_flag), .halt_flag(halt_flag), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .int_ack(int_ack)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_strobes(input string req, input logic [4:0] exp);
    check(req, {mem_rd, mem_wr, io_rd, io_wr, int_ack}, exp);
  endtask

  // one machine cycle: capture w, then a read window, then a write window
  task automatic run_cycle(input logic [7:0] w, input int etype);
    logic [4:0] rd_exp;
    logic [4:0] wr_exp;
    @(negedge clk);
    data_in = w; sync = 1'b1; dbin = 1'b0; wr_n = 1'b1;
    @(negedge clk);
    sync = 1'b0; data_in = 8'h5A;
    #2;
    check("R1 capture", status_word, w);
    check(etype == 15 ? "R4 type" : "R3 type", cyc_type, etype);
    check("R4 illegal flag", cyc_illegal, (etype == 15) ? 1 : 0);
    check("R10 flags", {fetch_flag, stack_flag, halt_flag}, {w[5], w[2], w[3]});
    check_strobes("R5 R6 R7 R8 R9 idle window", 5'b0);
    dbin = 1'b1;
    #2;
    // {mem_rd, mem_wr, io_rd, io_wr, int_ack}
    rd_exp = {w[7], 1'b0, w[6], 1'b0, w[0]};
    check_strobes("R5 R6 R9 read window", rd_exp);
    @(negedge clk);
    dbin = 1'b0; wr_n = 1'b0; data_in = 8'hC3;
    #2;
    check("R1 hold", status_word, w);
    wr_exp = {1'b0, (!w[4] && !w[1]), 1'b0, w[4], 1'b0};
    check_strobes("R7 R8 write window", wr_exp);
    wr_n = 1'b1;
    #2;
    check_strobes("R7 R8 write closed", 5'b0);
  endtask

  task automatic test_reset;
    rst_n = 1'b0; sync = 1'b0; dbin = 1'b1; wr_n = 1'b0; data_in = 8'h00;
    repeat (3) @(negedge clk);
    check("R2 reset word", status_word, 0);
    check("R2 reset valid", cyc_valid, 0);
    check("R2 reset type", cyc_type, 0);
    check_strobes("R2 reset strobes", 5'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    check("R2 before first sync type", cyc_type, 0);
    check("R2 before first sync illegal", cyc_illegal, 0);
    check_strobes("R2 before first sync strobes", 5'b0);
    dbin = 1'b0; wr_n = 1'b1;
  endtask

  task automatic test_store_instr;   // fetch, two operand reads, memory write
    run_cycle(8'hA2, 1);
    run_cycle(8'h82, 2);
    run_cycle(8'h82, 2);
    run_cycle(8'h00, 3);
  endtask

  task automatic test_push_pop;
    run_cycle(8'hA2, 1);
    run_cycle(8'h04, 5);
    run_cycle(8'h04, 5);
    run_cycle(8'hA2, 1);
    run_cycle(8'h86, 4);
    run_cycle(8'h86, 4);
  endtask

  task automatic test_ports;
    run_cycle(8'hA2, 1);
    run_cycle(8'h82, 2);
    run_cycle(8'h42, 6);
    run_cycle(8'h10, 7);
  endtask

  task automatic test_interrupt_halt;
    run_cycle(8'h23, 8);
    run_cycle(8'h8A, 9);
    run_cycle(8'h2B, 10);  // interrupt while halted: int_ack with halt flag
  endtask

  task automatic test_illegal;
    run_cycle(8'hFF, 15);
    run_cycle(8'h01, 15);
    run_cycle(8'hA3, 15);
    run_cycle(8'hA2, 1);   // recovers on next good word
  endtask

  task automatic test_hold_many;
    run_cycle(8'h42, 6);
    @(negedge clk);
    sync = 1'b0;
    for (int i = 0; i < 6; i++) begin
      data_in = 8'(8'h11 * i);
      @(negedge clk);
    end
    #2;
    check("R1 long hold", status_word, 8'h42);
    check("R3 type held", cyc_type, 6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    test_reset();
    test_store_instr();
    test_push_pop();
    test_ports();
    test_interrupt_halt();
    test_illegal();
    test_hold_many();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule